// File: doc/BRIEF.md
# Externally Sequenced Radix-4 Booth Multiplier

This block is an iterative 32x32 integer multiplier for an execution unit. It has two operand buses: `d1` is the multiplier that gets Booth-recoded, and `d2` is the multiplicand. A single result bus, `r`, carries the product. The multiplier has no sequencer of its own. A 7-bit operation word tells it to capture operands or to present a result. A 2-bit phase code from an outside controller tells it, cycle by cycle, whether to sit idle or to run one recoding step.

Each recoding step consumes four bits of `d1` as two radix-4 Booth digits and adds the matching multiples of `d2` into a 64-bit accumulator. A full multiply takes eight steps. When `d1` is known to be short, fewer steps are enough.

Booth recoding always reads `d1` as a signed number. An unsigned multiply whose upper half is wanted therefore needs one extra lower-phase step after the eight upper-phase steps. That step adds `d2` into the upper half of the accumulator whenever the top bit of `d1` was set.

Top module: `ext_seq_booth_mul`

## Requirements
- R1: After reset the accumulator is zero, so an unload before any load drives `r` = 0.
- R2: With `op_ctrl[6:4]` = 3'b110 and `seq_phase` = 2'b00 (idle), the block captures `d1` and `d2` and clears the accumulator. The type field `op_ctrl[2:1]` selects the operand type: 2'b01 is unsigned (`d2` zero-extended), 2'b00 is signed (`d2` sign-extended), and 2'b10 or 2'b11 is also handled as signed.
- R3: A load word presented while `seq_phase` is not idle has no effect on the operands or on the product.
- R4: Each cycle with `seq_phase` = 2'b01 (lower) or 2'b10 (upper) retires four bits of `d1`, least significant first, as two radix-4 Booth digits. The overlap bit starts at 0. After eight steps the accumulator holds the 64-bit product of signed `d1` and the extended `d2`.
- R5: If `d1` fits in n signed bits, with n a multiple of 4, then n/4 steps give the full product. Steps beyond that leave it unchanged.
- R6: After an unsigned load, the first lower-phase step that follows eight completed steps adds `d2` into accumulator bits [63:32`]`, but only if bit 31 of `d1` is 1. The upper half then equals the unsigned product's upper half.
- R7: With `op_ctrl[6:4]` = 3'b111, `r` shows accumulator bits [63:32] if any upper-phase step has occurred since the last load, and bits [31:0] otherwise. In every other cycle `r` is 0.
- R8: The accumulator holds while `seq_phase` is idle (apart from a load) and while `seq_phase` is the illegal code 2'b11.
- R9: No more than eight recoding steps take effect per load, and the sign correction is applied at most once per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_ctrl | input | 7 | Operation word: [6:4] operation (110 load, 111 unload), [2:1] operand type |
| seq_phase | input | 2 | Step code from the controller: 00 idle, 01 lower, 10 upper, 11 illegal |
| d1 | input | W | Multiplier operand (the one that is recoded) |
| d2 | input | W | Multiplicand operand |
| r | output | W | Result bus, driven only during unload |

## Verification
Signed operands with mixed signs, including -1 and 0x80000000, check the two's-complement digit multiples. Unsigned operands with the top bit of `d1` set (0xFFFFFFFF, 0x80000000) separate a correct upper-half correction from a missing or duplicated one. The same operands are read in both lower and upper mode, which checks the half selection. Short multipliers run with two or three steps check early termination. Extra steps, an illegal phase in the middle of a sequence, and a stray load word during stepping each show that state the design should leave alone is indeed left alone.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_LOWER = 2'b01,
    PH_UPPER = 2'b10,
    PH_BAD   = 2'b11
  } seq_phase_e;

  localparam logic [2:0] OP_LOAD   = 3'b110;
  localparam logic [2:0] OP_UNLOAD = 3'b111;
  localparam logic [1:0] TY_UNSIGNED = 2'b01;

  // Radix-4 Booth digit from a bit triplet {hi, mid, overlap}.
  function automatic logic signed [2:0] booth_digit(input logic [2:0] trip);
    logic signed [2:0] dg;
    case (trip)
      3'b001, 3'b010: dg = 3'sd1;
      3'b011:         dg = 3'sd2;
      3'b100:         dg = -3'sd2;
      3'b101, 3'b110: dg = -3'sd1;
      default:        dg = 3'sd0;
    endcase
    return dg;
  endfunction

endpackage

// File: rtl/mul_ctrl_decode.sv
module mul_ctrl_decode
  import booth_mul_pkg::*;
(
  input  logic [6:0] op_ctrl,
  input  logic [1:0] seq_phase,
  output logic       load_fire,
  output logic       unload_req,
  output logic       ld_unsigned,
  output logic       ph_idle,
  output logic       ph_lower,
  output logic       ph_upper
);
  logic [2:0] op_field;
  assign op_field    = op_ctrl[6:4];
  assign ph_idle     = (seq_phase == PH_IDLE);
  assign ph_lower    = (seq_phase == PH_LOWER);
  assign ph_upper    = (seq_phase == PH_UPPER);
  assign load_fire   = (op_field == OP_LOAD) && ph_idle;
  assign unload_req  = (op_field == OP_UNLOAD);
  assign ld_unsigned = (op_ctrl[2:1] == TY_UNSIGNED);
endmodule

// File: rtl/mul_operand_regs.sv
module mul_operand_regs #(
  parameter int W   = 32,
  parameter int DIG = 2,
  localparam int STEP_BITS = 2 * DIG,
  localparam int STEPS     = W / STEP_BITS,
  localparam int CW        = $clog2(STEPS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_fire,
  input  logic            doing,
  input  logic            ld_unsigned,
  input  logic [W-1:0]    d1,
  input  logic [W-1:0]    d2,
  output logic [W-1:0]    mplr,
  output logic            ovl,
  output logic [2*W-1:0]  mcand,
  output logic [W-1:0]    d2_keep,
  output logic            corr_need,
  output logic [CW-1:0]   step_cnt,
  output logic            step_fire
);
  localparam logic [CW-1:0] LAST = CW'(STEPS);

  assign step_fire = doing && (step_cnt < LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mplr      <= '0;
      ovl       <= 1'b0;
      mcand     <= '0;
      d2_keep   <= '0;
      corr_need <= 1'b0;
      step_cnt  <= '0;
    end else if (load_fire) begin
      mplr      <= d1;
      ovl       <= 1'b0;
      mcand     <= ld_unsigned ? {{W{1'b0}}, d2} : {{W{d2[W-1]}}, d2};
      d2_keep   <= d2;
      corr_need <= ld_unsigned && d1[W-1];
      step_cnt  <= '0;
    end else if (step_fire) begin
      mplr     <= {{STEP_BITS{mplr[W-1]}}, mplr[W-1:STEP_BITS]};
      ovl      <= mplr[STEP_BITS-1];
      mcand    <= mcand << STEP_BITS;
      step_cnt <= step_cnt + 1'b1;
    end
  end

  // R9
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt <= LAST);

  // R4
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !load_fire) |=> step_cnt == $past(step_cnt) + 1'b1);

endmodule

// File: rtl/mul_partial_sum.sv
module mul_partial_sum
  import booth_mul_pkg::*;
#(
  parameter int W   = 32,
  parameter int DIG = 2
) (
  input  logic [W-1:0]   mplr,
  input  logic           ovl,
  input  logic [2*W-1:0] mcand,
  output logic [2*W-1:0] psum
);
  // Multiple of the multiplicand selected by one Booth digit.
  function automatic logic [2*W-1:0] booth_term(input logic signed [2:0] dg,
                                                input logic [2*W-1:0] m);
    logic [2*W-1:0] t;
    case (dg)
      3'sd1:   t = m;
      3'sd2:   t = m << 1;
      -3'sd1:  t = -m;
      -3'sd2:  t = -(m << 1);
      default: t = '0;
    endcase
    return t;
  endfunction

  logic [2:0]     trip  [DIG];
  logic [2*W-1:0] terms [DIG];

  for (genvar j = 0; j < DIG; j++) begin : g_digit
    if (j == 0) begin : g_first
      assign trip[j] = {mplr[1:0], ovl};
    end else begin : g_rest
      assign trip[j] = mplr[2*j+1 : 2*j-1];
    end
    assign terms[j] = booth_term(booth_digit(trip[j]), mcand) << (2 * j);
  end

  always_comb begin
    psum = '0;
    for (int k = 0; k < DIG; k++) psum = psum + terms[k];
  end
endmodule

// File: rtl/mul_accum.sv
module mul_accum #(
  parameter int W   = 32,
  parameter int DIG = 2,
  localparam int STEPS = W / (2 * DIG),
  localparam int CW    = $clog2(STEPS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_fire,
  input  logic           step_fire,
  input  logic           ph_idle,
  input  logic           ph_lower,
  input  logic           ph_upper,
  input  logic           corr_need,
  input  logic [CW-1:0]  step_cnt,
  input  logic [2*W-1:0] psum,
  input  logic [W-1:0]   d2_keep,
  output logic [2*W-1:0] acc,
  output logic           upper_sel,
  output logic           corr_fire
);
  localparam logic [CW-1:0] LAST = CW'(STEPS);
  logic corr_done;

  assign corr_fire = ph_lower && (step_cnt == LAST) && corr_need && !corr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      upper_sel <= 1'b0;
      corr_done <= 1'b0;
    end else if (load_fire) begin
      acc       <= '0;
      upper_sel <= 1'b0;
      corr_done <= 1'b0;
    end else begin
      if (step_fire) acc <= acc + psum;
      else if (corr_fire) begin
        acc[2*W-1:W] <= acc[2*W-1:W] + d2_keep;
        corr_done    <= 1'b1;
      end
      if (ph_upper) upper_sel <= 1'b1;
    end
  end

  // R2
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (acc == '0) && !upper_sel);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_idle && !load_fire) |=> $stable(acc));

  // R6
  corr_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corr_fire |-> (step_cnt == LAST) && !step_fire);

  // R9
  corr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_fire && !load_fire) |=> !corr_fire);

endmodule

// File: rtl/ext_seq_booth_mul.sv
module ext_seq_booth_mul #(
  parameter int W   = 32,
  parameter int DIG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [6:0]   op_ctrl,
  input  logic [1:0]   seq_phase,
  input  logic [W-1:0] d1,
  input  logic [W-1:0] d2,
  output logic [W-1:0] r
);
  localparam int STEPS = W / (2 * DIG);
  localparam int CW    = $clog2(STEPS + 1);

  logic           load_fire, unload_req, ld_unsigned;
  logic           ph_idle, ph_lower, ph_upper;
  logic [W-1:0]   mplr, d2_keep;
  logic           ovl, corr_need, step_fire, corr_fire, upper_sel;
  logic [2*W-1:0] mcand, psum, acc;
  logic [CW-1:0]  step_cnt;

  mul_ctrl_decode u_dec (
    .op_ctrl, .seq_phase, .load_fire, .unload_req, .ld_unsigned,
    .ph_idle, .ph_lower, .ph_upper
  );

  mul_operand_regs #(.W(W), .DIG(DIG)) u_ops (
    .clk, .rst_n, .load_fire, .doing(ph_lower || ph_upper), .ld_unsigned,
    .d1, .d2, .mplr, .ovl, .mcand, .d2_keep, .corr_need, .step_cnt, .step_fire
  );

  mul_partial_sum #(.W(W), .DIG(DIG)) u_pp (
    .mplr, .ovl, .mcand, .psum
  );

  mul_accum #(.W(W), .DIG(DIG)) u_acc (
    .clk, .rst_n, .load_fire, .step_fire, .ph_idle, .ph_lower, .ph_upper,
    .corr_need, .step_cnt, .psum, .d2_keep, .acc, .upper_sel, .corr_fire
  );

  assign r = unload_req ? (upper_sel ? acc[2*W-1:W] : acc[W-1:0]) : '0;

  // R8
  bad_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_phase == 2'b11) |=> $stable(acc));

  // R3
  stray_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ctrl[6:4] == 3'b110 && !ph_idle) |=> $stable(d2_keep));

endmodule

// File: tb/test_ext_seq_booth_mul.sv
module test_ext_seq_booth_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  op_ctrl = '0;
  logic [1:0]  seq_phase = 2'b00;
  logic [31:0] d1 = '0, d2 = '0;
  logic [31:0] r;

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ext_seq_booth_mul i_ext_seq_booth_mul (
    .clk, .rst_n, .op_ctrl, .seq_phase, .d1, .d2, .r
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compare r during every unload cycle against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && op_ctrl[6:4] == 3'b111) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected unload actual %h expected none", r);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, r, e);
      end
    end
  end

  // Driver: one multiply; the expected value is computed from 64-bit math.
  task automatic run_mul(input logic [31:0] a, b, input logic [1:0] ty,
                         input bit hi, input int nsteps, input int extra_lo,
                         input bit bad_mid, input bit stray_ld, input string tag);
    logic [63:0] ea, eb, p;
    bit uns = (ty == 2'b01);
    ea = uns ? {32'b0, a} : {{32{a[31]}}, a};
    eb = uns ? {32'b0, b} : {{32{b[31]}}, b};
    p  = ea * eb;
    exp_q.push_back(hi ? p[63:32] : p[31:0]);
    tag_q.push_back(tag);
    op_ctrl = {3'b110, 1'b0, ty, 1'b0}; seq_phase = 2'b00; d1 = a; d2 = b;
    tick();
    op_ctrl = '0; d1 = ~a; d2 = b ^ 32'h5A5A_0F0F;
    for (int i = 0; i < nsteps; i++) begin
      if (bad_mid && i == 2) begin seq_phase = 2'b11; tick(); end
      op_ctrl = (stray_ld && i == 3) ? 7'b1100000 : 7'b0;
      seq_phase = hi ? 2'b10 : 2'b01;
      tick();
    end
    op_ctrl = '0;
    for (int i = 0; i < extra_lo; i++) begin seq_phase = 2'b01; tick(); end
    seq_phase = 2'b00;
    tick(); tick();
    op_ctrl = 7'b1110000;
    tick();
    op_ctrl = '0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1: unload before any load reads zero
    exp_q.push_back(32'h0); tag_q.push_back("R1 reset");
    op_ctrl = 7'b1110000; tick(); op_ctrl = '0;
    // R7: r is zero outside unload
    @(negedge clk); check("R7 idle bus", r, 32'h0); tick();

    run_mul(32'h0000_1234, 32'h0000_5678, 2'b00, 1'b0, 8, 0, 0, 0, "R4 signed lower");
    run_mul(32'hFFFF_FFFF, 32'h1234_5678, 2'b00, 1'b1, 8, 0, 0, 0, "R4 signed upper -1");
    run_mul(32'h8000_0000, 32'h8000_0000, 2'b00, 1'b1, 8, 0, 0, 0, "R4 signed min");
    run_mul(32'hDEAD_BEEF, 32'h0BAD_F00D, 2'b00, 1'b1, 8, 0, 0, 0, "R4 signed mixed");
    run_mul(32'h0000_0000, 32'hCAFE_BABE, 2'b00, 1'b1, 8, 0, 0, 0, "R4 zero");
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 1'b1, 8, 1, 0, 0, "R6 unsigned max upper");
    run_mul(32'h8000_0000, 32'h9ABC_DEF1, 2'b01, 1'b1, 8, 1, 0, 0, "R6 unsigned msb upper");
    run_mul(32'h7FFF_0001, 32'hF000_0003, 2'b01, 1'b1, 8, 0, 0, 0, "R2 unsigned no correction");
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 1'b0, 8, 0, 0, 0, "R2 unsigned lower");
    run_mul(32'hC000_0005, 32'h8765_4321, 2'b01, 1'b1, 8, 3, 0, 0, "R9 correction once");
    run_mul(32'hFFFF_FF9C, 32'h0123_4567, 2'b00, 1'b1, 2, 0, 0, 0, "R5 two steps");
    run_mul(32'h0000_04D2, 32'hFEDC_BA98, 2'b00, 1'b0, 3, 0, 0, 0, "R5 three steps");
    run_mul(32'hA5A5_1234, 32'h3C3C_7777, 2'b00, 1'b1, 11, 0, 0, 0, "R9 extra steps");
    run_mul(32'h1357_9BDF, 32'h2468_ACE0, 2'b00, 1'b1, 8, 0, 1, 0, "R8 illegal phase");
    run_mul(32'h7654_3210, 32'hFFFF_0000, 2'b00, 1'b1, 8, 0, 0, 1, "R3 stray load");
    run_mul(32'hF000_0001, 32'h8000_0001, 2'b10, 1'b1, 8, 0, 0, 0, "R2 type 10 signed");

    // R8: repeated unload after idle cycles returns the same product
    exp_q.push_back(32'hF000_0001 * 32'h8000_0001 >> 0 == 0 ? 32'h0 : 32'h0);
    tag_q.push_back("R8 hold");
    begin
      logic [63:0] p = {{32{1'b1}}, 32'hF000_0001} * {{32{1'b1}}, 32'h8000_0001};
      exp_q[exp_q.size()-1] = p[63:32];
    end
    tick(); tick(); tick();
    op_ctrl = 7'b1110000; tick(); op_ctrl = '0;
    tick(); tick();

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 pending results actual %0d expected 0", exp_q.size());
    end
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule